// File: doc/BRIEF.md
# Load/Store Address Adder with Range Flag

This block forms the word address used by a load or a store. It adds a base value, taken from a general register and read as an unsigned 32-bit number, to a 16-bit immediate offset, read as two's complement. The address it returns is the low 32 bits of that sum. Each address selects exactly one 32-bit word. A range flag is raised whenever the exact mathematical sum cannot be represented as an unsigned 32-bit value. That covers a result below zero and a result of 2^32 or more. The widened offset is also returned so that neighbouring logic can reuse it.

A parameter selects one of two builds. In the combinational build, the outputs follow the inputs within the same cycle. In the registered build, the address and the flag are captured on a clock edge where the strobe is high, and held at every other edge. A synchronous active-high reset clears them.

Top module: `ea_adder`

## Requirements
- R1: `ofs_wide` equals `ofs` sign-extended to 32 bits: bits 31..16 all copy bit 15 of `ofs`, and bits 15..0 equal `ofs`.
- R2: The address equals (`base` + sign-extended `ofs`) modulo 2^32.
- R3: `base` is unsigned. A base at or above 0x80000000, or a sum that crosses from 0x7FFFFFFF to 0x80000000, raises no flag.
- R4: `range_err` is 1 when `base` + offset is 2^32 or more. This case can arise only with a non-negative offset.
- R5: `range_err` is 1 when `base` + offset is below zero. This case can arise only with a negative offset.
- R6: `range_err` is 0 whenever 0 <= `base` + offset < 2^32. This includes both exact edges, a sum of 0 and a sum of 0xFFFFFFFF.
- R7: When `range_err` is 1, `addr` still carries the wrapped sum modulo 2^32.
- R8: With REGISTERED=1, a clock edge with `strobe`=1 and `rst`=0 loads `addr` and `range_err` from that cycle's inputs. The new values are visible after that edge.
- R9: With REGISTERED=1, a clock edge with `strobe`=0 and `rst`=0 leaves `addr` and `range_err` unchanged, whatever `base` and `ofs` do.
- R10: With REGISTERED=1, a clock edge with `rst`=1 sets `addr` to 0 and `range_err` to 0. Reset takes priority over `strobe`.
- R11: With REGISTERED=0, `addr` and `range_err` follow `base` and `ofs` in the same cycle, and `strobe` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered build |
| rst | input | 1 | Synchronous active-high reset for the output register |
| strobe | input | 1 | Capture enable for the registered build |
| base | input | 32 | Base value, unsigned |
| ofs | input | 16 | Offset, two's complement |
| addr | output | 32 | Word address, sum modulo 2^32 |
| range_err | output | 1 | Exact sum lies outside 0 .. 2^32-1 |
| ofs_wide | output | 32 | Offset sign-extended to 32 bits |

## Verification
The hardest cases to reach are the ones right at the two edges of the unsigned range. A sum of exactly 0 must be told apart from -1, and a sum of exactly 0xFFFFFFFF must be told apart from 2^32. A random base almost never lands on these points. The stimulus table therefore pairs bases such as 0x00008000, 0x00007FFF, 0xFFFF8000 and 0xFFFF8001 with the extreme offsets 0x8000 and 0x7FFF, so that each edge is hit from both sides. It also includes crossings of the signed midpoint that must not raise the flag.

// File: rtl/ea_adder.sv
module ea_adder #(
  parameter int BASE_W     = 32,
  parameter int OFS_W      = 16,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [BASE_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [BASE_W-1:0] addr,
  output logic              range_err,
  output logic [BASE_W-1:0] ofs_wide
);

  localparam int EXT_W = BASE_W - OFS_W;

  logic [BASE_W:0]   sum_full;
  logic [BASE_W-1:0] addr_next;
  logic              err_next;

  assign ofs_wide  = {{EXT_W{ofs[OFS_W-1]}}, ofs};
  assign sum_full  = {1'b0, base} + {1'b0, ofs_wide};
  assign addr_next = sum_full[BASE_W-1:0];
  // carry with a non-negative offset means too large; no carry with a negative one means below zero
  assign err_next  = sum_full[BASE_W] ^ ofs[OFS_W-1];

  generate
    if (REGISTERED) begin : g_reg
      logic [BASE_W-1:0] addr_q;
      logic              err_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q <= '0;
          err_q  <= 1'b0;
        end else if (strobe) begin
          addr_q <= addr_next;
          err_q  <= err_next;
        end
      end

      assign addr      = addr_q;
      assign range_err = err_q;

      AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (addr == '0 && !range_err)); // R10
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(addr) && $stable(range_err))); // R9
      AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (addr == $past(base + ofs_wide))); // R8
    end else begin : g_comb
      assign addr      = addr_next;
      assign range_err = err_next;
    end
  endgenerate

  AST_CARRY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!ofs[OFS_W-1] && err_next) |-> (addr_next < base)); // R4
  AST_BORROW_LOW: assert property (@(posedge clk) disable iff (rst)
    (ofs[OFS_W-1] && err_next) |-> (addr_next > base)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!ofs[OFS_W-1] && !err_next) |-> (addr_next >= base)); // R6
  AST_ZERO_OFS: assert property (@(posedge clk) disable iff (rst)
    (ofs == '0) |-> (addr_next == base && !err_next)); // R2

endmodule

// File: tb/tb_ea_adder.sv
`timescale 1ns/1ps
module tb_ea_adder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [31:0] base = '0;
  logic [15:0] ofs = '0;
  logic [31:0] addr, addr_c, wide, wide_c;
  logic        err, err_c;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ea_adder #(.REGISTERED(1'b1)) dut (
    .clk(clk), .rst(rst), .strobe(strobe), .base(base), .ofs(ofs),
    .addr(addr), .range_err(err), .ofs_wide(wide));

  ea_adder #(.REGISTERED(1'b0)) dut_c (
    .clk(clk), .rst(rst), .strobe(strobe), .base(base), .ofs(ofs),
    .addr(addr_c), .range_err(err_c), .ofs_wide(wide_c));

  localparam int NV = 14;
  // {base, ofs, expected addr, expected flag}
  localparam logic [80:0] VEC [NV] = '{
    {32'h00001000, 16'h0010, 32'h00001010, 1'b0},
    {32'h00001000, 16'hFFF0, 32'h00000FF0, 1'b0},
    {32'hFFFFFFFF, 16'h0001, 32'h00000000, 1'b1},
    {32'hFFFFFFF0, 16'h7FFF, 32'h00007FEF, 1'b1},
    {32'h00000000, 16'hFFFF, 32'hFFFFFFFF, 1'b1},
    {32'h00007FFF, 16'h8000, 32'hFFFFFFFF, 1'b1},
    {32'h00008000, 16'h8000, 32'h00000000, 1'b0},
    {32'hFFFFFFFF, 16'h0000, 32'hFFFFFFFF, 1'b0},
    {32'h80000000, 16'h7FFF, 32'h80007FFF, 1'b0},
    {32'h7FFFFFFF, 16'h0001, 32'h80000000, 1'b0},
    {32'hFFFF8000, 16'h7FFF, 32'hFFFFFFFF, 1'b0},
    {32'h00000005, 16'hFFFA, 32'hFFFFFFFF, 1'b1},
    {32'hFFFF8001, 16'h7FFF, 32'h00000000, 1'b1},
    {32'h12345678, 16'h8000, 32'h1233D678, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #40000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset addr", addr, 32'h0);
    check("R10 reset flag", {31'b0, err}, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] eb, ea, ew;
      logic [15:0] eo;
      logic        ee;
      {eb, eo, ea, ee} = VEC[i];
      ew = {{16{eo[15]}}, eo};
      @(negedge clk);
      base = eb; ofs = eo; strobe = 1'b1;
      #1;
      check("R11/R2/R7 comb addr", addr_c, ea);
      check("R4/R5/R6/R3 comb flag", {31'b0, err_c}, {31'b0, ee});
      check("R1 ofs_wide", wide_c, ew);
      @(negedge clk);
      strobe = 1'b0;
      check("R8 reg addr", addr, ea);
      check("R8 reg flag", {31'b0, err}, {31'b0, ee});
    end

    // hold: strobe low, inputs change (last captured: 0x1233D678, 0)
    @(negedge clk);
    base = 32'hFFFFFFFF; ofs = 16'h0001; strobe = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 hold addr", addr, 32'h1233D678);
    check("R9 hold flag", {31'b0, err}, 32'h0);
    check("R11 comb ignores strobe", addr_c, 32'h00000000);
    check("R11 comb flag", {31'b0, err_c}, 32'h1);

    // capture an overflow, then reset with strobe high
    strobe = 1'b1;
    @(negedge clk);
    check("R7 reg wrapped addr", addr, 32'h00000000);
    check("R4 reg flag", {31'b0, err}, 32'h1);
    base = 32'h00000010; ofs = 16'h0004;
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset over strobe addr", addr, 32'h0);
    check("R10 reset over strobe flag", {31'b0, err}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset", addr, 32'h00000014);
    strobe = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule